// File: doc/BRIEF.md
# Once-per-second time update sequencer with frozen user view

This block keeps seconds, minutes and hours in two copies. An internal counting chain advances once per second, driven by a 32.768 kHz tick enable. A user-visible copy is refreshed from the internal chain by a periodic transfer. A status bit goes high a fixed number of ticks before each transfer. Software that reads it low knows the visible bytes will not change for at least that long.

A freeze input stops the transfers while the internal chain keeps counting. While frozen, software may write any time field, and each write loads both copies at once. Each update also compares three alarm bytes with the new time. A byte whose top two bits are both set matches any value. The update and alarm events latch into sticky flags, which a single clear strobe resets.

Top module: `rtc_update_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all time bytes, the update-in-progress bit and both flags read 0. The tick prescaler restarts at zero.
- R2: The internal time advances by one second on every TICKS_PER_SEC-th tick, counted from reset. The count is binary. Seconds and minutes wrap from 59 to 0 and carry into the next field, and hours wrap from 23 to 0.
- R3: The update-in-progress bit rises on the tick that comes UIP_TICKS ticks before the transfer tick, which is tick index TICKS_PER_SEC-1-UIP_TICKS modulo TICKS_PER_SEC counted from reset. It stays high through the transfer and falls on the clock after the transfer.
- R4: Without freeze, each transfer loads the user bytes with the newly advanced internal time. The user bytes change at no other moment except through an accepted write.
- R5: While freeze is 1, transfers are suppressed and the user bytes hold their value, while the internal time keeps advancing. The first transfer after freeze returns to 0 shows the current internal time.
- R6: A write strobe with freeze at 1 loads the addressed field of both copies at the next clock edge. A write strobe with freeze at 0 has no effect. If a write and an update fall in the same cycle, the written field takes the written value in both copies.
- R7: The update-ended flag is set at every transfer tick, whether freeze is 0 or 1, and stays set until the clear strobe.
- R8: At each update, every alarm byte is compared with the corresponding newly advanced time byte. A byte with bits 7 and 6 both 1 is a don't-care. The alarm flag is set when all three positions match or are don't-care, and stays set until the clear strobe.
- R9: The clear strobe resets both flags. When it coincides with an event that sets a flag, the set takes priority for that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 32.768 kHz clock enable, one cycle wide |
| set_freeze | input | 1 | Freezes the user copy and enables writes |
| wr_sec | input | 1 | Write strobe for seconds |
| wr_min | input | 1 | Write strobe for minutes |
| wr_hr | input | 1 | Write strobe for hours |
| wr_data | input | 8 | Write data, binary |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| flag_clr | input | 1 | Clears the update-ended and alarm flags |
| usr_sec | output | 8 | User-visible seconds |
| usr_min | output | 8 | User-visible minutes |
| usr_hr | output | 8 | User-visible hours |
| uip | output | 1 | Update-in-progress status |
| upd_flag | output | 1 | Sticky update-ended flag |
| alm_flag | output | 1 | Sticky alarm flag |

## Verification
Two pairs of functions can share a cycle here. A flag clear can land on the transfer tick, and a frozen write can land on the tick that advances the internal chain. The bench steps the prescaler to the last tick of a second and applies the clear strobe or the write on that exact tick. It then checks that the flags stay set, and that the written field holds the written value both right away and after a later release of freeze, while the other fields show the carry of the advance.

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       set_freeze,
  input  logic       wr_sec,
  input  logic       wr_min,
  input  logic       wr_hr,
  input  logic [7:0] wr_data,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hr,
  input  logic       flag_clr,
  output logic [7:0] usr_sec,
  output logic [7:0] usr_min,
  output logic [7:0] usr_hr,
  output logic       uip,
  output logic       upd_flag,
  output logic       alm_flag
);
  localparam int CW    = $clog2(TICKS_PER_SEC);
  localparam int START = TICKS_PER_SEC - 1 - UIP_TICKS;

  logic [CW-1:0] presc;
  logic [7:0]    in_sec, in_min, in_hr;
  logic          xfer_q;

  wire last = tick && (presc == CW'(TICKS_PER_SEC - 1));
  wire warn = tick && (presc == CW'(START));

  wire sec_wrap = in_sec >= 8'd59;
  wire min_wrap = in_min >= 8'd59;
  wire hr_wrap  = in_hr  >= 8'd23;

  wire [7:0] nx_sec = sec_wrap ? 8'd0 : in_sec + 8'd1;
  wire [7:0] nx_min = !sec_wrap ? in_min : (min_wrap ? 8'd0 : in_min + 8'd1);
  wire [7:0] nx_hr  = !(sec_wrap && min_wrap) ? in_hr : (hr_wrap ? 8'd0 : in_hr + 8'd1);

  function automatic logic hit(input logic [7:0] a, input logic [7:0] t);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  wire match = hit(alm_sec, nx_sec) && hit(alm_min, nx_min) && hit(alm_hr, nx_hr);

  wire ws = wr_sec && set_freeze;
  wire wm = wr_min && set_freeze;
  wire wh = wr_hr  && set_freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
    end else if (tick) begin
      presc <= last ? '0 : presc + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sec <= '0;
      in_min <= '0;
      in_hr  <= '0;
    end else begin
      if (last) begin
        in_sec <= nx_sec;
        in_min <= nx_min;
        in_hr  <= nx_hr;
      end
      if (ws) in_sec <= wr_data;
      if (wm) in_min <= wr_data;
      if (wh) in_hr  <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_sec <= '0;
      usr_min <= '0;
      usr_hr  <= '0;
    end else begin
      if (last && !set_freeze) begin
        usr_sec <= nx_sec;
        usr_min <= nx_min;
        usr_hr  <= nx_hr;
      end
      if (ws) usr_sec <= wr_data;
      if (wm) usr_min <= wr_data;
      if (wh) usr_hr  <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uip    <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      xfer_q <= last;
      if (warn)        uip <= 1'b1;
      else if (xfer_q) uip <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_flag <= 1'b0;
      alm_flag <= 1'b0;
    end else begin
      if (last)          upd_flag <= 1'b1;
      else if (flag_clr) upd_flag <= 1'b0;
      if (last && match) alm_flag <= 1'b1;
      else if (flag_clr) alm_flag <= 1'b0;
    end
  end
endmodule

module rtc_update_seq_chk #(
  parameter int UIP_TICKS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       set_freeze,
  input logic       wr_sec,
  input logic       wr_min,
  input logic       wr_hr,
  input logic       flag_clr,
  input logic [7:0] usr_sec,
  input logic [7:0] usr_min,
  input logic [7:0] usr_hr,
  input logic       uip,
  input logic       upd_flag,
  input logic       alm_flag
);
  localparam int NW = $clog2(UIP_TICKS + 2) + 1;
  logic [NW-1:0] win;
  wire wr_ok = set_freeze && (wr_sec || wr_min || wr_hr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           win <= '0;
    else if (!uip)        win <= '0;
    else if (tick)        win <= win + NW'(1);
  end

  // R3: window length from rise to fall counted in ticks
  a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> (win == NW'(UIP_TICKS) || win == NW'(UIP_TICKS + 1)));

  // R3 and R7: the bit only falls after an update has been flagged
  a_r3_fall_after_update: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> $past(upd_flag));

  // R4: user bytes only move while uip was high or by an accepted write
  a_r4_quiet_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(uip) && !$past(wr_ok)) |-> $stable({usr_sec, usr_min, usr_hr}));

  // R5: frozen user copy holds without a write
  a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(set_freeze) && !$past(wr_ok)) |-> $stable({usr_sec, usr_min, usr_hr}));

  // R7 and R9: update flag only drops through the clear strobe
  a_r7_sticky_update: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_flag) |-> $past(flag_clr));

  // R8 and R9: alarm flag only drops through the clear strobe
  a_r8_sticky_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alm_flag) |-> $past(flag_clr));

  // R8: alarm is raised only by an update edge
  a_r8_raise_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm_flag) |-> (uip && upd_flag));
endmodule

bind rtc_update_seq rtc_update_seq_chk #(.UIP_TICKS(UIP_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .set_freeze(set_freeze),
  .wr_sec(wr_sec), .wr_min(wr_min), .wr_hr(wr_hr), .flag_clr(flag_clr),
  .usr_sec(usr_sec), .usr_min(usr_min), .usr_hr(usr_hr),
  .uip(uip), .upd_flag(upd_flag), .alm_flag(alm_flag)
);

// File: tb/sim_rtc_update_seq.sv
module sim_rtc_update_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TPS   = 32;
  localparam int UIPT  = 8;
  localparam int START = TPS - 1 - UIPT;

  logic clk = 0, rst_n = 0, tick = 0, set_freeze = 0;
  logic wr_sec = 0, wr_min = 0, wr_hr = 0, flag_clr = 0;
  logic [7:0] wr_data = 0, alm_sec = 8'd99, alm_min = 8'd99, alm_hr = 8'd99;
  logic [7:0] usr_sec, usr_min, usr_hr;
  logic uip, upd_flag, alm_flag;

  int checks = 0, errors = 0, k = 0;
  int mi_s = 0, mi_m = 0, mi_h = 0, mu_s = 0, mu_m = 0, mu_h = 0;
  logic m_uip = 0, m_upd = 0, m_alm = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_update_seq #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .set_freeze(set_freeze),
    .wr_sec(wr_sec), .wr_min(wr_min), .wr_hr(wr_hr), .wr_data(wr_data),
    .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr), .flag_clr(flag_clr),
    .usr_sec(usr_sec), .usr_min(usr_min), .usr_hr(usr_hr),
    .uip(uip), .upd_flag(upd_flag), .alm_flag(alm_flag));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (time %0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit amatch(input logic [7:0] a, input int t);
    return (a[7:6] == 2'b11) || (int'(a) == t);
  endfunction

  task automatic check_view(input string req);
    chk({req, " usr_sec"}, usr_sec, mu_s);
    chk({req, " usr_min"}, usr_min, mu_m);
    chk({req, " usr_hr"},  usr_hr,  mu_h);
    chk("R7 upd_flag", upd_flag, m_upd);
    chk("R8 alm_flag", alm_flag, m_alm);
  endtask

  // one tick (or none), optional clear and write on the same edge, then an idle cycle
  task automatic step(input bit do_tick, input bit clr, input int wf, input int wv);
    bit is_last, al;
    @(negedge clk);
    tick = do_tick; flag_clr = clr; wr_data = 8'(wv);
    wr_sec = (wf == 1); wr_min = (wf == 2); wr_hr = (wf == 3);
    @(negedge clk);
    tick = 0; flag_clr = 0; wr_sec = 0; wr_min = 0; wr_hr = 0;
    is_last = do_tick && (k == TPS - 1);
    al = 0;
    if (do_tick && k == START) m_uip = 1;
    if (is_last) begin
      mi_s++;
      if (mi_s >= 60) begin
        mi_s = 0; mi_m++;
        if (mi_m >= 60) begin
          mi_m = 0; mi_h++;
          if (mi_h >= 24) mi_h = 0;
        end
      end
      al = amatch(alm_sec, mi_s) && amatch(alm_min, mi_m) && amatch(alm_hr, mi_h);
      if (!set_freeze) begin mu_s = mi_s; mu_m = mi_m; mu_h = mi_h; end
    end
    if (set_freeze) begin
      if (wf == 1) begin mi_s = wv; mu_s = wv; end
      if (wf == 2) begin mi_m = wv; mu_m = wv; end
      if (wf == 3) begin mi_h = wv; mu_h = wv; end
    end
    if (is_last) m_upd = 1; else if (clr) m_upd = 0;
    if (is_last && al) m_alm = 1; else if (clr) m_alm = 0;
    if (do_tick) k = (k + 1) % TPS;
    chk("R3 uip after tick", uip, m_uip);
    check_view(set_freeze ? "R5" : "R4");
    @(negedge clk);
    if (is_last) m_uip = 0;
    chk("R3 uip after idle", uip, m_uip);
  endtask

  task automatic run_secs(input int n);
    for (int i = 0; i < n * TPS; i++) step(1, 0, 0, 0);
  endtask

  task automatic to_last();
    while (k != TPS - 1) step(1, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 usr_sec in reset", usr_sec, 0);
    chk("R1 uip in reset", uip, 0);
    rst_n = 1;
    @(negedge clk);
    check_view("R1");
    chk("R1 uip", uip, 0);

    // frozen writes load both copies
    set_freeze = 1;
    step(0, 0, 1, 50);
    step(0, 0, 2, 59);
    step(0, 0, 3, 23);
    chk("R6 write sec", usr_sec, 50);
    chk("R6 write hr", usr_hr, 23);
    set_freeze = 0;
    // write without freeze is ignored (model not updated)
    step(0, 0, 1, 7);
    chk("R6 ignored write", usr_sec, 50);

    // count across 23:59:59 -> 00:00:00
    run_secs(12);
    chk("R2 wrap hr", usr_hr, 0);
    chk("R2 wrap sec", usr_sec, 2);

    // clear flags alone
    step(0, 1, 0, 0);
    chk("R9 clear upd", upd_flag, 0);

    // freeze for 3 seconds, internal keeps running
    set_freeze = 1;
    run_secs(3);
    chk("R5 frozen sec", usr_sec, 2);
    chk("R7 flag while frozen", upd_flag, 1);
    set_freeze = 0;
    run_secs(1);
    chk("R5 resume sec", usr_sec, 6);

    // exact alarm two seconds ahead, then all don't-care, then no match
    step(0, 1, 0, 0);
    alm_sec = 8'(mi_s + 2); alm_min = 8'(mi_m); alm_hr = 8'(mi_h);
    run_secs(1);
    chk("R8 no early alarm", alm_flag, 0);
    run_secs(1);
    chk("R8 exact alarm", alm_flag, 1);
    step(0, 1, 0, 0);
    alm_sec = 8'hC0; alm_min = 8'hFF; alm_hr = 8'hC5;
    run_secs(2);
    chk("R8 dont-care alarm", alm_flag, 1);
    step(0, 1, 0, 0);
    alm_sec = 8'hC0; alm_min = 8'hC0; alm_hr = 8'd5;
    run_secs(2);
    chk("R8 hour mismatch", alm_flag, 0);

    // clear on the transfer tick: set wins
    alm_hr = 8'hC0;
    to_last();
    step(1, 1, 0, 0);
    chk("R9 set wins upd", upd_flag, 1);
    chk("R9 set wins alm", alm_flag, 1);

    // frozen write on the advance tick: written field wins, release shows it
    set_freeze = 1;
    to_last();
    step(1, 0, 2, 30);
    chk("R6 write on update", usr_min, 30);
    set_freeze = 0;
    run_secs(1);
    chk("R6 write kept in chain", usr_min, 30);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule